// File: doc/BRIEF.md
# Two-Level Transmit Cell Pacer

This block runs on the host bus clock and decides, once per slot, whether a batch of cells may be fetched from host memory and which transmit channel supplies it. A coarse stage wakes at a fixed interval and accumulates wake-ups in 16.8 fixed point. It declares a slot due when the accumulated count reaches a programmable global period. The fraction left over is kept, so the average slot rate matches a fractional period.

Each due slot is offered to a small set of channels. Every channel carries a traffic class and a per-channel fixed-point rate divisor. Urgent channels are always preferred. Paced channels are next and follow a virtual-time scheme: a shared virtual clock advances by 1.0 for every slot that a non-urgent channel wins. A paced channel may send once its own expiry time has been reached, and each send pushes its expiry forward by its divisor. Bulk channels take whatever slots remain. A resume strobe pulls a channel's expiry back to the current virtual time.

Top module: `pacer`

## Requirements
- R1: While reset is held and in the first cycle after it, `grant_valid` is 0 and `paced_time` is 0; every channel expiry also resets to 0.
- R2: The block wakes once every `WAKE_TICKS` (default 14) clock cycles, with the first wake in cycle `WAKE_TICKS` after reset release. A grant is a single-cycle pulse of `grant_valid` in the cycle right after a wake, so successive grants are a whole multiple of `WAKE_TICKS` cycles apart.
- R3: Every wake adds 1.0 (256 in 16.8 format) to an accumulator. A slot is due when the accumulator reaches the effective period, and the period is then subtracted, which keeps the remainder. The effective period is `global_period`, or 1.0 when `global_period` is below 1.0. Example: a period of 1.5 (0x180) gives grant gaps alternating between one and two wake intervals.
- R4: Class codes per 2-bit field of `chan_class` (channel i at bits 2i+1:2i) are: 0 bulk, 1 paced, 2 urgent, 3 bulk. In a due slot, the lowest-index backlogged urgent channel wins. If there is none, an eligible paced channel wins. If there is none, the lowest-index backlogged bulk channel wins. The winner always had `backlog` set in the wake cycle.
- R5: A paced channel is eligible when it is backlogged and its expiry is not later than `paced_time` (wrap-safe 32-bit difference). Among eligible paced channels the earliest expiry wins, and a tie goes to the lowest index.
- R6: `paced_time` (16.8 fixed point, 32 bits) rises by exactly 256 when a paced or bulk channel is granted. It is unchanged by urgent grants, by slots without a grant, and by resume.
- R7: When a paced channel is granted, its expiry grows by its 24-bit rate (16.8, channel i at `chan_rate` bits 24i+23:24i). For example, a rate of 2.0 lets it win every other non-urgent slot, and a rate of 1.5 lets it win two of every three.
- R8: A `resume` bit set at a clock edge sets that channel's expiry to the `paced_time` held before the edge. This overrides an expiry update from a grant at the same edge. The channel can then win the next due slot.
- R9: `grant_batch` carries the value of `batch_cells` sampled in the wake cycle, and `grant_ch` carries the winner's index.
- R10: A due slot in which no channel qualifies issues no grant and is still used up. A lone paced channel whose expiry is ahead therefore receives no further grants until it is resumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| global_period | input | FW (24) | Global slot period in wake-ups, 16.8 fixed point |
| batch_cells | input | BW (8) | Cells fetched per granted slot |
| chan_class | input | 2*NUM_CH | Per-channel traffic class code |
| chan_rate | input | FW*NUM_CH | Per-channel rate divisor, 16.8 fixed point |
| backlog | input | NUM_CH | Channel has cells waiting |
| resume | input | NUM_CH | Pull channel expiry back to current virtual time |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_ch | output | IW (2) | Index of the granted channel |
| grant_batch | output | BW (8) | Batch size carried with the grant |
| paced_time | output | VW (32) | Virtual clock, 16.8 fixed point |

## Verification
A wake decision is taken in the cycle where the tick counter reaches its last value. The grant pulse, its channel and batch, the new virtual time and the new expiry all become visible one clock later. A resume or backlog change made after an edge is seen at the following edge. The bench changes inputs just after the rising edge and advances a behavioural reference model at the same rising edges. At every falling edge it compares the grant pulse, the winner, the batch and `paced_time` with the model, so each result is checked in exactly the cycle it is due. Directed windows then count grants per channel and grant gaps to confirm priority, fractional rates, tie order, stalls and resume.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
    localparam int FIX_W  = 24;
    localparam int FRAC_W = 8;

    typedef enum logic [1:0] {
        CLS_BULK   = 2'd0,
        CLS_PACED  = 2'd1,
        CLS_URGENT = 2'd2,
        CLS_BULK2  = 2'd3
    } tx_class_e;
endpackage

// File: rtl/pacer_wake.sv
module pacer_wake
    import pacer_pkg::*;
#(
    parameter int WAKE_TICKS = 14,
    parameter int FW         = FIX_W,
    parameter int FB         = FRAC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] period_fx,
    output logic          wake,
    output logic          slot_due
);
    localparam int TW = (WAKE_TICKS > 1) ? $clog2(WAKE_TICKS) : 1;
    localparam int AW = FW + 1;
    localparam logic [AW-1:0] UNIT = {{(AW-1){1'b0}}, 1'b1} << FB;
    localparam logic [TW-1:0] LAST = TW'(WAKE_TICKS - 1);

    typedef struct packed {
        logic [TW-1:0] tick;
        logic [AW-1:0] acc;
    } wake_st_t;

    wake_st_t st_q, st_d;
    logic [AW-1:0] eff_period;
    logic [AW-1:0] acc_sum;

    always_comb begin
        st_d       = st_q;
        wake       = (st_q.tick == LAST);
        eff_period = ({1'b0, period_fx} < UNIT) ? UNIT : {1'b0, period_fx};
        acc_sum    = st_q.acc + UNIT;
        slot_due   = 1'b0;
        if (wake) begin
            st_d.tick = '0;
            slot_due  = (acc_sum >= eff_period);
            st_d.acc  = slot_due ? (acc_sum - eff_period) : acc_sum;
        end else begin
            st_d.tick = st_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pacer_arbiter.sv
module pacer_arbiter
    import pacer_pkg::*;
#(
    parameter int NCH = 4,
    parameter int VW  = 32,
    parameter int IW  = 2
) (
    input  logic [NCH-1:0][1:0]    cls,
    input  logic [NCH-1:0]         backlog,
    input  logic [NCH-1:0][VW-1:0] lag,
    output logic                   found,
    output logic [IW-1:0]          idx,
    output logic                   is_urgent,
    output logic                   is_paced
);
    logic [NCH-1:0] want_urgent, want_paced, want_bulk;
    logic [VW-1:0]  best_lag;

    // per-channel qualification; lag MSB clear means expiry not in the future
    for (genvar g = 0; g < NCH; g++) begin : g_qual
        assign want_urgent[g] = backlog[g] && (cls[g] == CLS_URGENT);
        assign want_paced[g]  = backlog[g] && (cls[g] == CLS_PACED) && !lag[g][VW-1];
        assign want_bulk[g]   = backlog[g] && ((cls[g] == CLS_BULK) || (cls[g] == CLS_BULK2));
    end

    always_comb begin
        found     = 1'b0;
        idx       = '0;
        is_urgent = 1'b0;
        is_paced  = 1'b0;
        best_lag  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (want_urgent[i] && !found) begin
                found     = 1'b1;
                idx       = IW'(i);
                is_urgent = 1'b1;
            end
        end
        if (!found) begin
            // largest lag = earliest expiry; strict compare keeps lower index on tie
            for (int i = 0; i < NCH; i++) begin
                if (want_paced[i] && (!found || (lag[i] > best_lag))) begin
                    found    = 1'b1;
                    idx      = IW'(i);
                    best_lag = lag[i];
                    is_paced = 1'b1;
                end
            end
        end
        if (!found) begin
            for (int i = 0; i < NCH; i++) begin
                if (want_bulk[i] && !found) begin
                    found = 1'b1;
                    idx   = IW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/pacer.sv
module pacer
    import pacer_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int WAKE_TICKS = 14,
    parameter int FW         = FIX_W,
    parameter int FB         = FRAC_W,
    parameter int VW         = 32,
    parameter int BW         = 8,
    localparam int IW        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FW-1:0]        global_period,
    input  logic [BW-1:0]        batch_cells,
    input  logic [2*NUM_CH-1:0]  chan_class,
    input  logic [FW*NUM_CH-1:0] chan_rate,
    input  logic [NUM_CH-1:0]    backlog,
    input  logic [NUM_CH-1:0]    resume,
    output logic                 grant_valid,
    output logic [IW-1:0]        grant_ch,
    output logic [BW-1:0]        grant_batch,
    output logic [VW-1:0]        paced_time
);
    localparam logic [VW-1:0] VONE = {{(VW-1){1'b0}}, 1'b1} << FB;

    typedef struct packed {
        logic [VW-1:0]              vtime;
        logic [NUM_CH-1:0][VW-1:0]  expiry;
        logic                       gv;
        logic [IW-1:0]              gch;
        logic [BW-1:0]              gbatch;
    } pacer_st_t;

    pacer_st_t st_q, st_d;

    logic                      wake_w, slot_due;
    logic [NUM_CH-1:0][1:0]    cls_v;
    logic [NUM_CH-1:0][VW-1:0] rate_v;
    logic [NUM_CH-1:0][VW-1:0] lag_v;
    logic                      win_found, win_urgent, win_paced;
    logic [IW-1:0]             win_idx;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign cls_v[g]  = chan_class[2*g +: 2];
        assign rate_v[g] = VW'(chan_rate[FW*g +: FW]);
        assign lag_v[g]  = st_q.vtime - st_q.expiry[g];
    end

    pacer_wake #(
        .WAKE_TICKS (WAKE_TICKS),
        .FW         (FW),
        .FB         (FB)
    ) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_fx (global_period),
        .wake      (wake_w),
        .slot_due  (slot_due)
    );

    pacer_arbiter #(
        .NCH (NUM_CH),
        .VW  (VW),
        .IW  (IW)
    ) u_arb (
        .cls       (cls_v),
        .backlog   (backlog),
        .lag       (lag_v),
        .found     (win_found),
        .idx       (win_idx),
        .is_urgent (win_urgent),
        .is_paced  (win_paced)
    );

    always_comb begin
        st_d    = st_q;
        st_d.gv = 1'b0;
        if (slot_due && win_found) begin
            st_d.gv     = 1'b1;
            st_d.gch    = win_idx;
            st_d.gbatch = batch_cells;
            if (!win_urgent) st_d.vtime = st_q.vtime + VONE;
            if (win_paced)   st_d.expiry[win_idx] = st_q.expiry[win_idx] + rate_v[win_idx];
        end
        // resume overrides any same-edge expiry update
        for (int i = 0; i < NUM_CH; i++) begin
            if (resume[i]) st_d.expiry[i] = st_q.vtime;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_valid = st_q.gv;
    assign grant_ch    = st_q.gch;
    assign grant_batch = st_q.gbatch;
    assign paced_time  = st_q.vtime;
endmodule

// File: rtl/pacer_chk.sv
module pacer_chk #(
    parameter int NUM_CH = 4,
    parameter int IW     = 2,
    parameter int VW     = 32,
    parameter int BW     = 8,
    parameter int FB     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wake,
    input logic              grant_valid,
    input logic [IW-1:0]     grant_ch,
    input logic [BW-1:0]     grant_batch,
    input logic [VW-1:0]     paced_time,
    input logic [NUM_CH-1:0] backlog,
    input logic [BW-1:0]     batch_cells
);
    localparam logic [VW-1:0] VONE = {{(VW-1){1'b0}}, 1'b1} << FB;

    assert_grant_after_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $past(wake));

    assert_grant_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid);

    assert_winner_backlogged_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (|(($past(backlog) >> grant_ch) & NUM_CH'(1))));

    assert_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (32'(grant_ch) < NUM_CH));

    assert_vtime_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> $stable(paced_time));

    assert_vtime_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((paced_time == $past(paced_time)) ||
                         (paced_time == $past(paced_time) + VONE)));

    assert_batch_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_batch == $past(batch_cells)));
endmodule

bind pacer pacer_chk #(
    .NUM_CH (NUM_CH),
    .IW     (IW),
    .VW     (VW),
    .BW     (BW),
    .FB     (FB)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wake        (wake_w),
    .grant_valid (grant_valid),
    .grant_ch    (grant_ch),
    .grant_batch (grant_batch),
    .paced_time  (paced_time),
    .backlog     (backlog),
    .batch_cells (batch_cells)
);

// File: tb/tb_pacer.sv
`timescale 1ns/1ps
module tb_pacer;
    localparam int NCH = 4;
    localparam int WT  = 14;
    localparam int ONE = 256;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic [23:0] gp;
    logic [7:0]  batch;
    logic [7:0]  cls;
    logic [95:0] rate;
    logic [3:0]  bl, rs;
    logic        gv;
    logic [1:0]  gch;
    logic [7:0]  gb;
    logic [31:0] pt;

    pacer dut (
        .clk(clk), .rst_n(rst_n), .global_period(gp), .batch_cells(batch),
        .chan_class(cls), .chan_rate(rate), .backlog(bl), .resume(rs),
        .grant_valid(gv), .grant_ch(gch), .grant_batch(gb), .paced_time(pt)
    );

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model, advanced at every rising edge
    int m_tick, m_acc, m_vt, m_gch, m_gb;
    int m_ex[NCH];
    bit m_gv;

    always @(posedge clk) begin : model
        int  win, kind, eff, old_vt, best, lagv, c;
        bit  wk, due;
        if (!rst_n) begin
            m_tick = 0; m_acc = 0; m_vt = 0; m_gv = 0; m_gch = 0; m_gb = 0;
            for (int i = 0; i < NCH; i++) m_ex[i] = 0;
        end else begin
            wk = (m_tick == WT - 1);
            m_tick = wk ? 0 : m_tick + 1;
            due = 0;
            if (wk) begin
                m_acc += ONE;
                eff = (int'(gp) < ONE) ? ONE : int'(gp);
                if (m_acc >= eff) begin due = 1; m_acc -= eff; end
            end
            old_vt = m_vt;
            m_gv = 0;
            if (due) begin
                win = -1; kind = 0; best = -1;
                for (int i = 0; i < NCH; i++) begin
                    c = int'(cls[2*i +: 2]);
                    if (win < 0 && bl[i] && c == 2) begin win = i; kind = 2; end
                end
                if (win < 0) begin
                    for (int i = 0; i < NCH; i++) begin
                        c = int'(cls[2*i +: 2]);
                        lagv = old_vt - m_ex[i];
                        if (bl[i] && c == 1 && lagv >= 0 && lagv > best) begin
                            win = i; best = lagv; kind = 1;
                        end
                    end
                end
                if (win < 0) begin
                    for (int i = 0; i < NCH; i++) begin
                        c = int'(cls[2*i +: 2]);
                        if (win < 0 && bl[i] && (c == 0 || c == 3)) begin win = i; kind = 0; end
                    end
                end
                if (win >= 0) begin
                    m_gv = 1; m_gch = win; m_gb = int'(batch);
                    if (kind != 2) m_vt = m_vt + ONE;
                    if (kind == 1) m_ex[win] = m_ex[win] + int'(rate[24*win +: 24]);
                end
            end
            for (int i = 0; i < NCH; i++) if (rs[i]) m_ex[i] = old_vt;
        end
    end

    // grant statistics and per-cycle comparison at the falling edge
    int cyc = 0, ngr, last_t, n14, n28, nother, last_gb, seq_n;
    int gcnt[NCH];
    int seq[4];

    task automatic clear_stats();
        for (int i = 0; i < NCH; i++) gcnt[i] = 0;
        ngr = 0; last_t = -1; n14 = 0; n28 = 0; nother = 0; seq_n = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n === 1'b1 && !done) begin
            chk(gv === m_gv, "R2 grant pulse", gv, m_gv);
            if (gv && m_gv) begin
                chk(int'(gch) == m_gch, "R5 winner", gch, m_gch);
                chk(int'(gb) == m_gb, "R9 batch", gb, m_gb);
            end
            chk(pt == 32'(m_vt), "R6 paced_time", pt, m_vt);
            if (gv) begin
                gcnt[gch]++; ngr++; last_gb = int'(gb);
                if (seq_n < 4) begin seq[seq_n] = int'(gch); seq_n++; end
                if (last_t >= 0) begin
                    if (cyc - last_t == WT) n14++;
                    else if (cyc - last_t == 2*WT) n28++;
                    else nother++;
                end
                last_t = cyc;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_cls(input int ch, input int c);
        cls[2*ch +: 2] = c[1:0];
    endtask

    task automatic set_rate(input int ch, input int r);
        rate[24*ch +: 24] = r[23:0];
    endtask

    task automatic pulse_resume(input logic [3:0] m);
        rs = m; step(1); rs = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R2 actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        int pt0;
        rst_n = 0; gp = 24'd256; batch = 8'd4; cls = '0; rate = '0; bl = '0; rs = '0;
        for (int i = 0; i < NCH; i++) set_rate(i, ONE);
        clear_stats();
        step(3);
        chk(gv == 1'b0, "R1 reset grant", gv, 0);
        chk(pt == 0, "R1 reset paced_time", pt, 0);
        rst_n = 1;
        step(1);
        chk(gv == 1'b0 && pt == 0, "R1 after release", pt, 0);

        // no backlog: no grants, virtual time frozen
        clear_stats();
        step(WT * 6);
        chk(ngr == 0, "R10 idle no grant", ngr, 0);
        chk(pt == 0, "R6 idle paced_time", pt, 0);

        // wake spacing with period 1.0
        bl = 4'b0001;
        clear_stats();
        step(WT * 30);
        chk(nother == 0 && n28 == 0 && n14 > 20, "R2 gap one wake", n14, 29);

        // fractional period 1.5
        gp = 24'h000180;
        clear_stats();
        step(WT * 30);
        chk(nother == 0 && n28 > 0, "R3 gaps of 1 or 2 wakes", nother, 0);
        chk((n14 - n28) <= 1 && (n28 - n14) <= 1, "R3 fraction averages", n14, n28);

        // period below 1.0 acts as 1.0
        gp = 24'd100;
        clear_stats();
        step(WT * 20);
        chk(nother == 0 && n28 == 0 && n14 > 15, "R3 floor at one", n14, 19);

        // class priority: urgent wins and does not move virtual time
        gp = 24'd256;
        set_cls(0, 0); set_cls(1, 1); set_cls(2, 2); set_cls(3, 3);
        bl = 4'b0111;
        pulse_resume(4'b0010);
        clear_stats();
        pt0 = int'(pt);
        step(WT * 10);
        chk(ngr > 0 && gcnt[2] == ngr, "R4 urgent first", gcnt[2], ngr);
        chk(int'(pt) == pt0, "R6 urgent holds paced_time", pt, pt0);

        // paced rate 1.0 beats bulk every slot
        bl = 4'b0011;
        clear_stats();
        step(WT * 10);
        chk(ngr > 0 && gcnt[1] == ngr, "R4 paced over bulk", gcnt[1], ngr);

        // paced rate 2.0 gets every other slot
        set_rate(1, 512);
        bl = 4'b0000;
        pulse_resume(4'b0010);
        bl = 4'b0011;
        clear_stats();
        step(WT * 20);
        chk(ngr > 10 && (2*gcnt[1] - ngr) <= 1 && (ngr - 2*gcnt[1]) <= 1, "R7 rate 2.0 half", gcnt[1], ngr/2);

        // paced rate 1.5 gets two of three slots
        set_rate(1, 384);
        bl = 4'b0000;
        pulse_resume(4'b0010);
        bl = 4'b0011;
        clear_stats();
        step(WT * 30);
        chk(ngr > 20 && (3*gcnt[1] - 2*ngr) <= 3 && (2*ngr - 3*gcnt[1]) <= 3, "R7 rate 1.5 two thirds", gcnt[1], (2*ngr)/3);

        // bulk: lowest index, class code 3 also bulk
        bl = 4'b1001;
        clear_stats();
        step(WT * 5);
        chk(ngr > 0 && gcnt[0] == ngr, "R4 bulk lowest index", gcnt[0], ngr);
        bl = 4'b1000;
        clear_stats();
        step(WT * 5);
        chk(ngr > 0 && gcnt[3] == ngr, "R4 class 3 as bulk", gcnt[3], ngr);

        // tie between two paced channels
        set_cls(2, 0); set_cls(3, 1);
        set_rate(1, 512); set_rate(3, 512);
        bl = 4'b0000;
        pulse_resume(4'b1010);
        bl = 4'b1010;
        clear_stats();
        step(WT * 4);
        chk(seq_n >= 2 && seq[0] == 1, "R5 tie lowest index", seq[0], 1);
        chk(seq_n >= 2 && seq[1] == 3, "R5 earliest expiry next", seq[1], 3);

        // lone slow paced channel stalls until resumed
        set_rate(1, 24'h000A00);
        bl = 4'b0000;
        pulse_resume(4'b0010);
        bl = 4'b0010;
        step(WT * 2);
        clear_stats();
        pt0 = int'(pt);
        step(WT * 8);
        chk(ngr == 0, "R10 stalled no grant", ngr, 0);
        chk(int'(pt) == pt0, "R6 stalled paced_time", pt, pt0);
        pulse_resume(4'b0010);
        clear_stats();
        step(WT * 2);
        chk(gcnt[1] == 1, "R8 resume re-enables", gcnt[1], 1);

        // batch size carried
        set_cls(0, 0);
        bl = 4'b0001;
        batch = 8'd9;
        clear_stats();
        step(WT * 3);
        chk(ngr > 0 && last_gb == 9, "R9 batch value", last_gb, 9);

        finish_run();
    end
endmodule